// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block is the multi-cycle control path of an 8-bit processor with a 16-bit address space. It handles the control transfers that move the program counter through the stack or through a fixed vector. These are the startup vector load, entry into a non-maskable or maskable interrupt, the software break, return from interrupt and return from subroutine. It owns the stack pointer, the program counter and the status byte, and it drives a single-port memory. That memory takes an address, write data and a write enable in one cycle and returns read data on the next.

The instruction decoder starts a break, interrupt return or subroutine return with a one-cycle strobe. It marks the last cycle of every other instruction with `instr_end`, and pending interrupts are considered only in that cycle. The non-maskable request is edge-captured into a pending latch, so a one-cycle pulse is not lost while a sequence runs. The maskable request is a level input that the interrupt-disable flag gates. Every sequence ends with a one-cycle `done` pulse. The stack always lives in one fixed page. The break flag in a pushed status byte shows whether the push came from hardware or from software.

Top module: `irq_stack_seq`

## Requirements
- R1: The stack occupies page 0x01. A push writes to {0x01, sp} in its own cycle and then decrements sp. A pull increments sp and then reads {0x01, sp+1} in its own cycle. sp wraps modulo 256.
- R2: While reset is held, sp is 0xFD, status is 0x34 and mem_we is 0. After release, pc low is read from 0xFFFC and pc high from 0xFFFD, and `done` then pulses.
- R3: A hardware interrupt pushes pc[15:8], then pc[7:0], then status with bit 4 cleared and the other bits unchanged. It then loads the vector low byte and high byte. `done` rises 6 cycles after the sampling cycle.
- R4: A rising edge on nmi_req sets a pending latch that persists until the interrupt is serviced. At a sampling point a pending NMI is taken ahead of any IRQ. It vectors through 0xFFFA (low) and 0xFFFB (high), leaves status bit 2 unchanged, and clears the latch.
- R5: An IRQ is taken only when status bit 2 (interrupt disable) is 0. Taking it sets bit 2 and vectors through 0xFFFE/0xFFFF. With bit 2 set the request causes no access and no change to pc or sp.
- R6: A break strobe first increments pc. It then pushes pc high, pc low and status with bits 4 and 5 set, sets bit 2, and vectors through 0xFFFE/0xFFFF. `done` rises 6 cycles after the strobe cycle.
- R7: Return from interrupt pulls status and ORs in 0x30, then pulls pc low, then pc high. `done` rises 4 cycles after the strobe cycle.
- R8: Return from subroutine pulls pc low, then pc high, then adds 1 to the full 16-bit pc, carrying into the high byte. `done` rises 3 cycles after the strobe cycle.
- R9: Interrupts are sampled only in an idle cycle with instr_end high. Start strobes and instr_end that arrive while a sequence runs have no effect.
- R10: `done` is high for exactly one cycle, the cycle after the last memory access. `busy` is high from the first cycle of a sequence through the `done` cycle and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_end | input | 1 | Last cycle of an ordinary instruction; interrupt sampling point |
| nmi_req | input | 1 | Non-maskable request, edge-captured |
| irq_req | input | 1 | Maskable request, level |
| start_brk | input | 1 | Start software break |
| start_rti | input | 1 | Start return from interrupt |
| start_rts | input | 1 | Start return from subroutine |
| mem_rdata | input | 8 | Read data, valid the cycle after the address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status byte (bit 2 interrupt disable) |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sends a non-maskable pulse in the middle of a subroutine return. It then checks that the pulse waits through an interrupt return and wins over a held maskable request at the next sampling point. A design with a level-sampled or early-cleared latch would lose that interrupt or take it too soon. The pushed status bytes are read back from the stack to tell a hardware push (bit 4 clear) from a break push (bits 4 and 5 set), and a swapped mask would show there. Other cases cover a pull sequence that wraps the stack pointer through 0xFF, a subroutine return whose low byte 0xFF must carry into the high byte, a masked request that must do nothing, and a break strobe sent mid-sequence that must not start a second sequence.

// File: rtl/irq_stack_seq.sv
module irq_stack_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT    = 8'hFD,
  parameter logic [7:0]  P_INIT     = 8'h34,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_end,
  input  logic        nmi_req,
  input  logic        irq_req,
  input  logic        start_brk,
  input  logic        start_rti,
  input  logic        start_rts,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic [7:0]  status,
  output logic        busy,
  output logic        done
);
  localparam int         IBIT   = 2;
  localparam logic [7:0] M_BRK  = 8'h10;
  localparam logic [7:0] M_HIGH = 8'h30;

  typedef enum logic [3:0] {S_IDLE, S_PSH_H, S_PSH_L, S_PSH_P, S_VEC_L, S_VEC_H,
                            S_PUL_P, S_PUL_L, S_PUL_H, S_FIN} st_t;
  typedef enum logic [2:0] {K_RST, K_NMI, K_IRQ, K_BRK, K_RTI, K_RTS} kind_t;
  typedef enum logic [1:0] {C_NONE, C_PCL, C_PCH, C_P} cap_t;

  st_t   st;
  kind_t kind;
  cap_t  cap;
  logic  nmi_d, nmi_pend;

  wire        nmi_rise = nmi_req & ~nmi_d;
  wire [7:0]  sp_up    = sp + 8'd1;
  wire [15:0] vec_base = (kind == K_RST) ? VEC_RST : (kind == K_NMI) ? VEC_NMI : VEC_IRQ;
  wire        sample   = (st == S_IDLE) && instr_end;
  wire        take_nmi = sample && nmi_pend;
  wire        take_irq = sample && !nmi_pend && irq_req && !status[IBIT];

  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = {STACK_PAGE, sp};
    mem_wdata = 8'h00;
    case (st)
      S_PSH_H: begin mem_we = 1'b1; mem_wdata = pc[15:8]; end
      S_PSH_L: begin mem_we = 1'b1; mem_wdata = pc[7:0]; end
      S_PSH_P: begin
        mem_we    = 1'b1;
        mem_wdata = (kind == K_BRK) ? (status | M_HIGH) : (status & ~M_BRK);
      end
      S_VEC_L: mem_addr = vec_base;
      S_VEC_H: mem_addr = vec_base + 16'd1;
      S_PUL_P, S_PUL_L, S_PUL_H: mem_addr = {STACK_PAGE, sp_up};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_VEC_L;
      kind     <= K_RST;
      cap      <= C_NONE;
      pc       <= 16'h0000;
      sp       <= SP_INIT;
      status   <= P_INIT;
      nmi_d    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_d <= nmi_req;
      cap   <= C_NONE;
      if (st == S_VEC_H && kind == K_NMI) nmi_pend <= 1'b0;
      if (nmi_rise) nmi_pend <= 1'b1;

      case (cap)
        C_PCL:   pc[7:0] <= mem_rdata;
        C_PCH:   pc <= (kind == K_RTS) ? {mem_rdata, pc[7:0]} + 16'd1 : {mem_rdata, pc[7:0]};
        C_P:     status <= mem_rdata | M_HIGH;
        default: ;
      endcase

      case (st)
        S_IDLE: begin
          if (take_nmi) begin
            kind <= K_NMI; st <= S_PSH_H;
          end else if (take_irq) begin
            kind <= K_IRQ; st <= S_PSH_H;
          end else if (start_brk) begin
            kind <= K_BRK; st <= S_PSH_H; pc <= pc + 16'd1;
          end else if (start_rti) begin
            kind <= K_RTI; st <= S_PUL_P;
          end else if (start_rts) begin
            kind <= K_RTS; st <= S_PUL_L;
          end
        end
        S_PSH_H: begin sp <= sp - 8'd1; st <= S_PSH_L; end
        S_PSH_L: begin sp <= sp - 8'd1; st <= S_PSH_P; end
        S_PSH_P: begin sp <= sp - 8'd1; st <= S_VEC_L; end
        S_VEC_L: begin
          cap <= C_PCL;
          if (kind == K_IRQ || kind == K_BRK) status[IBIT] <= 1'b1;
          st <= S_VEC_H;
        end
        S_VEC_H: begin cap <= C_PCH; st <= S_FIN; end
        S_PUL_P: begin sp <= sp_up; cap <= C_P;   st <= S_PUL_L; end
        S_PUL_L: begin sp <= sp_up; cap <= C_PCL; st <= S_PUL_H; end
        S_PUL_H: begin sp <= sp_up; cap <= C_PCH; st <= S_FIN; end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module irq_stack_seq_chk #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic [7:0]  sp,
  input logic        busy,
  input logic        done
);
  p_stack_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == STACK_PAGE);
  p_push_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 8'd1);
  p_push_at_sp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[7:0] == sp);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_we_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
endmodule

bind irq_stack_seq irq_stack_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .sp(sp), .busy(busy), .done(done)
);

// File: tb/tb_irq_stack_seq.sv
`timescale 1ns/1ps
module tb_irq_stack_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_end = 1'b0, nmi_req = 1'b0, irq_req = 1'b0;
  logic start_brk = 1'b0, start_rti = 1'b0, start_rts = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] mem_addr, pc;
  logic [7:0]  mem_wdata, sp, status;
  logic        mem_we, busy, done;
  logic [7:0]  stk [256];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_stack_seq dut (
    .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .nmi_req(nmi_req), .irq_req(irq_req),
    .start_brk(start_brk), .start_rti(start_rti), .start_rts(start_rts),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .pc(pc), .sp(sp), .status(status), .busy(busy), .done(done)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    case (a)
      16'hFFFA: rd = 8'h00;
      16'hFFFB: rd = 8'h90;
      16'hFFFC: rd = 8'h00;
      16'hFFFD: rd = 8'hC0;
      16'hFFFE: rd = 8'h00;
      16'hFFFF: rd = 8'h80;
      default:  rd = (a[15:8] == 8'h01) ? stk[a[7:0]] : 8'hEA;
    endcase
  endfunction

  always @(posedge clk) begin
    mem_rdata <= rd(mem_addr);
    if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op: 0 subroutine return, 1 interrupt return, 2 break, 3 sampling point with irq held
  // fields: op[39:37] nmi_pulse[36] cycles[35:32] pc[31:16] sp[15:8] status[7:0]
  localparam logic [39:0] TBL [7] = '{
    {3'd0, 1'b1, 4'd3, 16'h1234, 8'hFF, 8'h34},
    {3'd1, 1'b0, 4'd4, 16'h5678, 8'h02, 8'h30},
    {3'd3, 1'b0, 4'd6, 16'h9000, 8'hFF, 8'h30},
    {3'd3, 1'b0, 4'd6, 16'h8000, 8'hFC, 8'h34},
    {3'd2, 1'b0, 4'd6, 16'h8000, 8'hF9, 8'h34},
    {3'd1, 1'b0, 4'd4, 16'h8001, 8'hFC, 8'h34},
    {3'd0, 1'b0, 4'd3, 16'h0021, 8'hFE, 8'h34}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: tag_of = "R8";
      1: tag_of = "R7";
      2: tag_of = "R4";
      3: tag_of = "R5";
      4: tag_of = "R6";
      5: tag_of = "R7";
      default: tag_of = "R8";
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input logic pulse, input logic brk_mid, output int n);
    @(negedge clk);
    case (op)
      3'd0: start_rts = 1'b1;
      3'd1: start_rti = 1'b1;
      3'd2: start_brk = 1'b1;
      default: begin instr_end = 1'b1; irq_req = 1'b1; end
    endcase
    @(negedge clk);
    start_rts = 1'b0; start_rti = 1'b0; start_brk = 1'b0; instr_end = 1'b0; irq_req = 1'b0;
    n = 1;
    nmi_req = pulse;
    start_brk = brk_mid;
    while (!done && n < 20) begin
      @(negedge clk);
      nmi_req = 1'b0;
      start_brk = 1'b0;
      n++;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    foreach (stk[i]) stk[i] = 8'h00;
    stk[8'hFE] = 8'h33; stk[8'hFF] = 8'h12;
    stk[8'h00] = 8'h00; stk[8'h01] = 8'h78; stk[8'h02] = 8'h56;

    repeat (3) @(negedge clk);
    chk("R2 sp in reset", sp, 8'hFD);
    chk("R2 status in reset", status, 8'h34);
    chk("R2 no write in reset", mem_we, 1'b0);
    rst_n = 1'b1;
    n = 0;
    while (!done && n < 20) begin @(negedge clk); n++; end
    chk("R10 startup done", done, 1'b1);
    @(negedge clk);
    chk("R10 done single cycle", done, 1'b0);
    chk("R2 startup pc", pc, 16'hC000);

    for (int i = 0; i < 7; i++) begin
      logic [39:0] e;
      e = TBL[i];
      run(e[39:37], e[36], 1'b0, n);
      chk({tag_of(i), " cycles"}, n, e[35:32]);
      @(negedge clk);
      chk("R10 done low after", done, 1'b0);
      chk("R10 busy low after", busy, 1'b0);
      chk({tag_of(i), " pc"}, pc, e[31:16]);
      chk({tag_of(i), " sp"}, sp, e[15:8]);
      chk({tag_of(i), " status"}, status, e[7:0]);
    end

    chk("R4 nmi push pch", stk[8'h02], 8'h56);
    chk("R4 nmi push pcl", stk[8'h01], 8'h78);
    chk("R3 hw push status bit4 clear", stk[8'h00], 8'h20);
    chk("R3 irq push pch", stk[8'hFF], 8'h90);
    chk("R3 irq push pcl", stk[8'hFE], 8'h00);
    chk("R3 irq push status", stk[8'hFD], 8'h20);
    chk("R6 brk push pch", stk[8'hFC], 8'h80);
    chk("R6 brk push pcl incremented", stk[8'hFB], 8'h01);
    chk("R6 brk push status bits 4 5", stk[8'hFA], 8'h34);

    // R5 masked request: status bit 2 is set, nothing may happen
    @(negedge clk);
    instr_end = 1'b1; irq_req = 1'b1;
    @(negedge clk);
    instr_end = 1'b0;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      if (busy) n++;
      @(negedge clk);
    end
    irq_req = 1'b0;
    chk("R5 masked irq no sequence", n, 0);
    chk("R5 masked irq pc", pc, 16'h0021);
    chk("R5 masked irq sp", sp, 8'hFE);

    // R8 carry into high byte, R9 break strobe mid-sequence ignored
    stk[8'hFF] = 8'hFF; stk[8'h00] = 8'h12;
    run(3'd0, 1'b0, 1'b1, n);
    chk("R8 carry cycles", n, 3);
    @(negedge clk);
    chk("R8 carry pc", pc, 16'h1300);
    chk("R8 carry sp", sp, 8'h00);
    n = 0;
    for (int k = 0; k < 6; k++) begin
      if (busy) n++;
      @(negedge clk);
    end
    chk("R9 strobe while busy ignored", n, 0);
    chk("R9 sp untouched", sp, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule